// File: doc/BRIEF.md
# Shifter Operand Unit with Carry-Out

This block sits in the execute stage of a RISC integer datapath and forms the second ALU operand. It takes a 32-bit value, a 2-bit shift kind and a shift amount, and returns the shifted value together with the shifter carry-out. That carry-out is later used as the carry flag by the logical instructions. A mode input chooses where the amount comes from. It is either a 5-bit field held in the instruction word, or the low 8 bits of a register. The unit is purely combinational and has no clock or reset.

Some amount encodings do not mean what they literally say. A zero instruction-held amount stands for a shift by 32 on the right shifts, and for a one-bit rotate through the carry flag on a rotate. Register amounts of 32 or more saturate, and each shift kind has its own carry rule in that range. An amount decoder sorts every request into one of eight operating classes:

- `CL_PASS`: the value and the carry flag pass through unchanged.
- `CL_NORMAL`: a true shift by 1 to 31.
- `CL_CLEAR_B0`: the result is zero and the carry is bit 0.
- `CL_CLEAR_B31`: the result is zero and the carry is bit 31.
- `CL_CLEAR_C0`: the result is zero and the carry is zero.
- `CL_SIGN`: every bit is the sign bit, and so is the carry.
- `CL_RRX`: a one-bit rotate through the carry flag.
- `CL_ROT_WHOLE`: a rotate by a nonzero multiple of 32, which leaves the value unchanged and carries out bit 31.

A log-depth barrel shifter serves the `CL_NORMAL` class. An output selector then picks the result and the carry for the decoded class.

Top module: `shifter_operand_unit`

## Requirements
- R1: The shift kind encoding is 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right. When `amt_sel_reg_i` is 1 the amount is `reg_amt_i`, and `imm_amt_i` has no effect. When it is 0 the amount is `imm_amt_i`, and `reg_amt_i` has no effect.
- R2: An instruction-held logical left shift by n places the value shifted left by n on `result_o`. For n > 0 the carry-out is input bit 32-n. For n = 0 the value is unchanged and the carry-out is `carry_i`.
- R3: An instruction-held logical right or arithmetic right with amount 0 behaves as a shift by 32. Logical right gives zero, arithmetic right gives 32 copies of bit 31, and in both cases the carry-out is input bit 31.
- R4: An instruction-held logical right, arithmetic right or rotate right with nonzero amount n gives the shifted or rotated value, with carry-out equal to input bit n-1.
- R5: An instruction-held rotate right with amount 0 gives `{carry_i, value[31:1]}` and a carry-out equal to input bit 0.
- R6: A register amount of 0 passes the value through unchanged for every shift kind, with carry-out equal to `carry_i`.
- R7: A register logical left or logical right by exactly 32 gives zero. The carry-out is bit 0 for left and bit 31 for right. By more than 32 (up to 255), both shifts give zero with carry-out 0.
- R8: A register arithmetic right by 32 to 255 gives 32 copies of bit 31, and the carry-out is bit 31.
- R9: A register rotate right uses only amount bits [4:0]. A nonzero amount whose low five bits are zero leaves the value unchanged, with carry-out equal to input bit 31.
- R10: A register amount from 1 to 31 gives the same result and carry-out as the instruction-held amount of the same value, for every shift kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 32 | Value to be shifted |
| kind_i | input | 2 | Shift kind (0 left, 1 logical right, 2 arithmetic right, 3 rotate right) |
| imm_amt_i | input | 5 | Amount taken from the instruction word |
| reg_amt_i | input | 8 | Amount taken from the low byte of a register |
| amt_sel_reg_i | input | 1 | 1 selects `reg_amt_i`, 0 selects `imm_amt_i` |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The assertions are evaluated whenever the combinational logic settles. They take for granted that every input is a defined 0 or 1, because the checks compare popcounts and equalities that X values would make meaningless. The bench drives every input, including the amount field that is not selected, with a known value in the same step. Each result is read only after half a clock period, so an assertion never sees a partly updated input set. The sweep covers every shift kind, every instruction-held amount and every register amount, against a reference that the bench computes with 64-bit arithmetic.

// File: rtl/shift_pkg.sv
package shift_pkg;

    typedef enum logic [1:0] {
        SK_LSL = 2'd0,
        SK_LSR = 2'd1,
        SK_ASR = 2'd2,
        SK_ROR = 2'd3
    } shift_kind_e;

    typedef enum logic [2:0] {
        CL_PASS      = 3'd0,
        CL_NORMAL    = 3'd1,
        CL_CLEAR_B0  = 3'd2,
        CL_CLEAR_B31 = 3'd3,
        CL_CLEAR_C0  = 3'd4,
        CL_SIGN      = 3'd5,
        CL_RRX       = 3'd6,
        CL_ROT_WHOLE = 3'd7
    } shift_class_e;

endpackage

// File: rtl/shift_amount_decode.sv
module shift_amount_decode
    import shift_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int REG_W  = 8,
    localparam int SHW   = $clog2(DATA_W)
) (
    input  shift_kind_e        kind_i,
    input  logic               sel_reg_i,
    input  logic [SHW-1:0]     imm_amt_i,
    input  logic [REG_W-1:0]   reg_amt_i,
    output shift_class_e       cls_o,
    output logic [SHW-1:0]     amt_o
);

    localparam logic [REG_W-1:0] FULL_AMT = REG_W'(DATA_W);

    logic imm_zero;
    logic reg_zero;
    logic reg_full;
    logic reg_over;
    logic reg_low_zero;

    always_comb begin
        imm_zero     = (imm_amt_i == '0);
        reg_zero     = (reg_amt_i == '0);
        reg_full     = (reg_amt_i == FULL_AMT);
        reg_over     = (reg_amt_i >  FULL_AMT);
        reg_low_zero = (reg_amt_i[SHW-1:0] == '0);
    end

    always_comb begin
        cls_o = CL_PASS;
        amt_o = '0;
        if (!sel_reg_i) begin
            amt_o = imm_amt_i;
            unique case (kind_i)
                SK_LSL: cls_o = imm_zero ? CL_PASS      : CL_NORMAL;
                SK_LSR: cls_o = imm_zero ? CL_CLEAR_B31 : CL_NORMAL;
                SK_ASR: cls_o = imm_zero ? CL_SIGN      : CL_NORMAL;
                SK_ROR: cls_o = imm_zero ? CL_RRX       : CL_NORMAL;
                default: cls_o = CL_PASS;
            endcase
        end else if (reg_zero) begin
            cls_o = CL_PASS;
        end else begin
            amt_o = reg_amt_i[SHW-1:0];
            unique case (kind_i)
                SK_LSL: begin
                    if (reg_over)      cls_o = CL_CLEAR_C0;
                    else if (reg_full) cls_o = CL_CLEAR_B0;
                    else               cls_o = CL_NORMAL;
                end
                SK_LSR: begin
                    if (reg_over)      cls_o = CL_CLEAR_C0;
                    else if (reg_full) cls_o = CL_CLEAR_B31;
                    else               cls_o = CL_NORMAL;
                end
                SK_ASR: cls_o = (reg_over || reg_full) ? CL_SIGN : CL_NORMAL;
                SK_ROR: cls_o = reg_low_zero ? CL_ROT_WHOLE : CL_NORMAL;
                default: cls_o = CL_PASS;
            endcase
        end
    end

    always_comb begin
        if (cls_o == CL_NORMAL) begin
            AST_NORMAL_NONZERO: assert (amt_o != '0) else $error("normal class with zero amount"); // R4
        end
        if (sel_reg_i && reg_zero) begin
            AST_REG_ZERO_CLASS: assert (cls_o == CL_PASS) else $error("zero register amount not passed"); // R6
        end
    end

endmodule

// File: rtl/shift_barrel.sv
module shift_barrel
    import shift_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int SHW   = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] data_i,
    input  shift_kind_e       kind_i,
    input  logic [SHW-1:0]    amt_i,
    output logic [DATA_W-1:0] data_o
);

    logic [DATA_W-1:0] stg [0:SHW];
    logic              fill;

    always_comb begin
        fill   = (kind_i == SK_ASR) ? data_i[DATA_W-1] : 1'b0;
        stg[0] = data_i;
    end

    for (genvar s = 0; s < SHW; s++) begin : g_stage
        localparam int STEP = 1 << s;
        logic [DATA_W-1:0] moved;
        always_comb begin
            unique case (kind_i)
                SK_LSL:  moved = {stg[s][DATA_W-1-STEP:0], {STEP{1'b0}}};
                SK_LSR,
                SK_ASR:  moved = {{STEP{fill}}, stg[s][DATA_W-1:STEP]};
                SK_ROR:  moved = {stg[s][STEP-1:0], stg[s][DATA_W-1:STEP]};
                default: moved = stg[s];
            endcase
            stg[s+1] = amt_i[s] ? moved : stg[s];
        end
    end

    assign data_o = stg[SHW];

endmodule

// File: rtl/shift_outsel.sv
module shift_outsel
    import shift_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int SHW   = $clog2(DATA_W)
) (
    input  shift_class_e      cls_i,
    input  shift_kind_e       kind_i,
    input  logic [SHW-1:0]    amt_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [DATA_W-1:0] barrel_i,
    input  logic              carry_i,
    output logic [DATA_W-1:0] result_o,
    output logic              carry_o
);

    logic [SHW:0] bit_idx;
    logic         normal_carry;
    logic         sign_bit;

    always_comb begin
        sign_bit = data_i[DATA_W-1];
        if (kind_i == SK_LSL) begin
            bit_idx = (SHW+1)'(DATA_W) - {1'b0, amt_i};
        end else begin
            bit_idx = {1'b0, amt_i} - (SHW+1)'(1);
        end
        normal_carry = data_i[bit_idx[SHW-1:0]];
    end

    always_comb begin
        unique case (cls_i)
            CL_PASS: begin
                result_o = data_i;
                carry_o  = carry_i;
            end
            CL_NORMAL: begin
                result_o = barrel_i;
                carry_o  = normal_carry;
            end
            CL_CLEAR_B0: begin
                result_o = '0;
                carry_o  = data_i[0];
            end
            CL_CLEAR_B31: begin
                result_o = '0;
                carry_o  = sign_bit;
            end
            CL_CLEAR_C0: begin
                result_o = '0;
                carry_o  = 1'b0;
            end
            CL_SIGN: begin
                result_o = {DATA_W{sign_bit}};
                carry_o  = sign_bit;
            end
            CL_RRX: begin
                result_o = {carry_i, data_i[DATA_W-1:1]};
                carry_o  = data_i[0];
            end
            CL_ROT_WHOLE: begin
                result_o = data_i;
                carry_o  = sign_bit;
            end
            default: begin
                result_o = data_i;
                carry_o  = carry_i;
            end
        endcase
    end

endmodule

// File: rtl/shifter_operand_unit.sv
module shifter_operand_unit
    import shift_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int REG_W  = 8,
    localparam int SHW   = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] opnd_i,
    input  logic [1:0]        kind_i,
    input  logic [SHW-1:0]    imm_amt_i,
    input  logic [REG_W-1:0]  reg_amt_i,
    input  logic              amt_sel_reg_i,
    input  logic              carry_i,
    output logic [DATA_W-1:0] result_o,
    output logic              carry_o
);

    shift_kind_e       kind;
    shift_class_e      cls;
    logic [SHW-1:0]    eff_amt;
    logic [DATA_W-1:0] barrel_out;

    assign kind = shift_kind_e'(kind_i);

    shift_amount_decode #(
        .DATA_W (DATA_W),
        .REG_W  (REG_W)
    ) u_decode (
        .kind_i    (kind),
        .sel_reg_i (amt_sel_reg_i),
        .imm_amt_i (imm_amt_i),
        .reg_amt_i (reg_amt_i),
        .cls_o     (cls),
        .amt_o     (eff_amt)
    );

    shift_barrel #(
        .DATA_W (DATA_W)
    ) u_barrel (
        .data_i (opnd_i),
        .kind_i (kind),
        .amt_i  (eff_amt),
        .data_o (barrel_out)
    );

    shift_outsel #(
        .DATA_W (DATA_W)
    ) u_outsel (
        .cls_i    (cls),
        .kind_i   (kind),
        .amt_i    (eff_amt),
        .data_i   (opnd_i),
        .barrel_i (barrel_out),
        .carry_i  (carry_i),
        .result_o (result_o),
        .carry_o  (carry_o)
    );

    localparam logic [REG_W-1:0] FULL_AMT = REG_W'(DATA_W);

    always_comb begin
        if (amt_sel_reg_i && reg_amt_i == '0) begin
            AST_REG_ZERO_PASS: assert (result_o == opnd_i && carry_o == carry_i) else $error("zero amount altered data"); // R6
        end
        if (amt_sel_reg_i && (kind == SK_LSL || kind == SK_LSR) && reg_amt_i > FULL_AMT) begin
            AST_WIDE_CLEAR: assert (result_o == '0 && !carry_o) else $error("wide logical shift not cleared"); // R7
        end
        if (amt_sel_reg_i && kind == SK_ASR && reg_amt_i >= FULL_AMT) begin
            AST_ASR_SAT: assert (result_o == {DATA_W{opnd_i[DATA_W-1]}} && carry_o == opnd_i[DATA_W-1]) else $error("arith saturation wrong"); // R8
        end
        if (kind == SK_ROR && (amt_sel_reg_i || imm_amt_i != '0)) begin
            AST_ROR_BITS_KEPT: assert ($countones(result_o) == $countones(opnd_i)) else $error("rotate lost bits"); // R9
        end
        if (!amt_sel_reg_i && kind == SK_LSR && imm_amt_i == '0) begin
            AST_IMM_ZERO_LSR: assert (result_o == '0 && carry_o == opnd_i[DATA_W-1]) else $error("zero imm logical right wrong"); // R3
        end
    end

endmodule

// File: tb/tb_shifter_operand_unit.sv
module tb_shifter_operand_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] opnd;
    logic [1:0]  kind;
    logic [4:0]  imm_amt;
    logic [7:0]  reg_amt;
    logic        sel_reg;
    logic        cin;
    logic [31:0] result;
    logic        cout;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    shifter_operand_unit dut (
        .opnd_i        (opnd),
        .kind_i        (kind),
        .imm_amt_i     (imm_amt),
        .reg_amt_i     (reg_amt),
        .amt_sel_reg_i (sel_reg),
        .carry_i       (cin),
        .result_o      (result),
        .carry_o       (cout)
    );

    // arithmetic reference for shifts by e >= 1 (e may exceed 32)
    task automatic ref_shift(input logic [1:0] k, input int e, input logic [31:0] x,
                             output logic [31:0] r, output logic c);
        logic [63:0] w;
        int m;
        m = (e > 63) ? 63 : e;
        case (k)
            2'd0: begin
                w = (e > 63) ? 64'd0 : ({32'd0, x} << m);
                r = w[31:0];
                c = w[32];
            end
            2'd1: begin
                w = (e > 63) ? 64'd0 : ({x, 32'd0} >> m);
                r = w[63:32];
                c = w[31];
            end
            2'd2: begin
                w = $signed({x, 32'd0}) >>> m;
                r = w[63:32];
                c = w[31];
            end
            default: begin
                int q;
                q = e % 32;
                if (q == 0) begin
                    r = x;
                    c = x[31];
                end else begin
                    r = (x >> q) | (x << (32 - q));
                    c = x[q-1];
                end
            end
        endcase
    endtask

    task automatic reference(input logic [1:0] k, input logic sr, input logic [4:0] ia,
                             input logic [7:0] ra, input logic [31:0] x, input logic ci,
                             output logic [31:0] r, output logic c);
        if (sr) begin
            if (ra == 0) begin
                r = x;
                c = ci;
            end else begin
                ref_shift(k, int'(ra), x, r, c);
            end
        end else begin
            if (ia == 0) begin
                case (k)
                    2'd0: begin r = x; c = ci; end
                    2'd3: begin r = {ci, x[31:1]}; c = x[0]; end
                    default: ref_shift(k, 32, x, r, c);
                endcase
            end else begin
                ref_shift(k, int'(ia), x, r, c);
            end
        end
    endtask

    function automatic string req_tag(input logic [1:0] k, input logic sr,
                                      input logic [4:0] ia, input logic [7:0] ra);
        if (!sr) begin
            if (k == 2'd0) return "R2";
            if (ia == 0) return (k == 2'd3) ? "R5" : "R3";
            return "R4";
        end
        if (ra == 0) return "R6";
        if (ra < 32) return "R10";
        if (k == 2'd2) return "R8";
        if (k == 2'd3) return "R9";
        return "R7";
    endfunction

    task automatic apply(input logic [1:0] k, input logic sr, input logic [4:0] ia,
                         input logic [7:0] ra, input logic [31:0] x, input logic ci,
                         input string extra);
        logic [31:0] er;
        logic        ec;
        @(posedge clk);
        kind = k; sel_reg = sr; imm_amt = ia; reg_amt = ra; opnd = x; cin = ci;
        @(negedge clk);
        reference(k, sr, ia, ra, x, ci, er, ec);
        total++;
        if (result !== er || cout !== ec) begin
            bad++;
            $display("FAIL %s%s kind=%0d sel=%0b imm=%0d reg=%0d x=%h cin=%0b: got %h/%0b expected %h/%0b",
                     req_tag(k, sr, ia, ra), extra, k, sr, ia, ra, x, ci, result, cout, er, ec);
        end
    endtask

    initial begin
        opnd = '0; kind = '0; imm_amt = '0; reg_amt = '0; sel_reg = 1'b0; cin = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // quiet start: all-zero inputs give zero out (R2 pass case)
        @(negedge clk);
        total++;
        if (result !== 32'd0 || cout !== 1'b0) begin
            bad++;
            $display("FAIL R2 idle: got %h/%0b expected 0/0", result, cout);
        end

        // instruction-held amounts, all kinds, all 32 amounts; reg_amt junk (R1)
        for (int k = 0; k < 4; k++) begin
            for (int a = 0; a < 32; a++) begin
                for (int p = 0; p < 6; p++) begin
                    logic [31:0] x;
                    case (p)
                        0: x = 32'h0000_0000;
                        1: x = 32'hFFFF_FFFF;
                        2: x = 32'h8000_0001;
                        3: x = 32'h7FFF_FFFE;
                        4: x = 32'hA5C3_0F96;
                        default: x = $urandom;
                    endcase
                    apply(2'(k), 1'b0, 5'(a), 8'($urandom), x, p[0], " R1");
                end
            end
        end

        // register amounts 0..255, all kinds; imm_amt junk (R1)
        for (int k = 0; k < 4; k++) begin
            for (int a = 0; a < 256; a++) begin
                for (int p = 0; p < 4; p++) begin
                    logic [31:0] x;
                    case (p)
                        0: x = 32'h8000_0001;
                        1: x = 32'h4000_0002;
                        2: x = 32'hDEAD_BEEF;
                        default: x = $urandom;
                    endcase
                    apply(2'(k), 1'b1, 5'($urandom), 8'(a), x, p[1], " R1");
                end
            end
        end

        // R10: register 1..31 equals instruction-held same amount
        for (int k = 0; k < 4; k++) begin
            for (int a = 1; a < 32; a++) begin
                logic [31:0] x;
                logic [31:0] r_imm;
                logic        c_imm;
                x = $urandom;
                @(posedge clk);
                kind = 2'(k); sel_reg = 1'b0; imm_amt = 5'(a); reg_amt = 8'd0; opnd = x; cin = 1'b1;
                @(negedge clk);
                r_imm = result; c_imm = cout;
                @(posedge clk);
                sel_reg = 1'b1; imm_amt = 5'd0; reg_amt = 8'(a);
                @(negedge clk);
                total++;
                if (result !== r_imm || cout !== c_imm) begin
                    bad++;
                    $display("FAIL R10 kind=%0d amt=%0d: got %h/%0b expected %h/%0b",
                             k, a, result, cout, r_imm, c_imm);
                end
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule